// File: doc/BRIEF.md
# Queue Event-State Page Controller

This block is a memory-mapped slave that owns the two-bit event-state (pending / queued) fields of a set of event queues. Every queue is given a pair of adjacent address pages. An access to the lower page of the pair works on the queue's notification state field. An access to the upper page works on its escalation state field. Both fields are kept in word 1 of the queue's descriptor, which sits in an external descriptor store.

For each accepted access the block does the following. It decodes the queue number and the page parity from the address. It decodes the operation from the low twelve address bits. It fetches the descriptor word and applies the event-state rule. It writes the word back only when the selected field actually changed, and then it answers. The operations are: end-of-interrupt by load or by store, read of the state, forced set of the state, and trigger by store.

The sequencer has five states:
- IDLE accepts a request. It moves to FETCH when the decode is legal, and to REPLY with an error when it is not.
- FETCH holds the descriptor read request until the data returns. It moves to APPLY when the descriptor is valid, and to REPLY with an error when it is not.
- APPLY computes the new state. It moves to WRITE when the field changed, and to REPLY when it did not.
- WRITE issues one write-back and moves to REPLY.
- REPLY gives one response and returns to IDLE.

Top module: `esb_page_ctrl`

## Requirements
- R1: The queue number is the address shifted right by PAGE_SHIFT+1. Address bit PAGE_SHIFT selects the field: 0 selects the notification field (descriptor bits [5:4], P at bit 5), and 1 selects the escalation field (bits [1:0], P at bit 1).
- R2: Only address bits [11:0] select the operation. The load operations are: 0x000-0x7FF end-of-interrupt, 0x800-0xBFF get, 0xC00-0xFFF set. With PAGE_SHIFT=16, bits 15:12 have no effect.
- R3: A load end-of-interrupt returns 1 in bit 0 only when the old state was 11. It moves the state 11→10 and 10→00, and leaves 00 and 01 unchanged.
- R4: A get load returns the current state in bits [1:0] (upper bits zero) and does not change it.
- R5: A set load in window 0xC00+n·0x100 returns the old state in bits [1:0] and stores n (offset bits [9:8]) as the new state.
- R6: A store to 0x000-0x3FF is a trigger. It moves 00→10, 10→11 and 11→11, and leaves 01 unchanged. It responds with data 0.
- R7: A store to 0x400-0x7FF is an end-of-interrupt. It follows the transition rule of R3 and responds with data 0.
- R8: The descriptor is written back exactly when the selected field changes. All other bits of the word are preserved.
- R9: An error response (rsp_err=1, data all ones, no write-back) is given for any of these: size code other than 3 (8 bytes), queue number ≥ NUM_Q, a store at 0x800-0xFFF, or a fetched descriptor marked invalid.
- R10: req_ready is high only in IDLE. Each accepted request produces exactly one rsp_valid pulse, and requests are served in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle when both are high |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address within the page array |
| req_size | input | 2 | log2 of access bytes; only 3 is legal |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 64 | Load result, 0 for stores, all ones on error |
| rsp_err | output | 1 | Access rejected |
| desc_rd_req | output | 1 | Descriptor read request, held until data returns |
| desc_idx | output | IDX_W | Queue number for descriptor read or write |
| desc_rd_valid | input | 1 | Descriptor read data present |
| desc_rd_ok | input | 1 | Fetched descriptor is valid |
| desc_rd_word | input | WORD_W | Fetched descriptor word 1 |
| desc_wr_en | output | 1 | Descriptor word 1 write-back strobe |
| desc_wr_word | output | WORD_W | Updated descriptor word 1 |

## Verification
Two activities can meet in the same cycle: the reply to one access, and a second access that is already waiting on the request port for the same queue. The bench provokes this by holding req_valid high with a trigger followed at once by a get to that queue. The get must be accepted only after the first reply. It must also return the state that the trigger just wrote back (10), not the state read before the trigger.

// File: rtl/esb_pkg.sv
package esb_pkg;

    typedef enum logic [2:0] {
        OP_LD_EOI,
        OP_GET,
        OP_SET,
        OP_TRIG,
        OP_ST_EOI,
        OP_BAD
    } esb_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_APPLY,
        ST_WRITE,
        ST_REPLY
    } esb_state_e;

    localparam logic [1:0] SIZE_8B = 2'd3;
    localparam int         OFF_W   = 12;

endpackage

// File: rtl/esb_addr_decode.sv
module esb_addr_decode
    import esb_pkg::*;
#(
    parameter int NUM_Q      = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 3,
    parameter int ADDR_W     = 16
) (
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [IDX_W-1:0]  idx,
    output logic              esc_sel,
    output esb_op_e           op,
    output logic [1:0]        set_val,
    output logic              legal
);
    logic [OFF_W-1:0] off;
    logic             range_ok;

    assign idx      = addr[ADDR_W-1 -: IDX_W];
    assign esc_sel  = addr[PAGE_SHIFT];
    assign off      = addr[OFF_W-1:0];
    assign set_val  = off[9:8];
    assign range_ok = ({1'b0, idx} < (IDX_W+1)'(NUM_Q));

    always_comb begin
        if (!write) begin
            if (!off[11])
                op = OP_LD_EOI;
            else if (!off[10])
                op = OP_GET;
            else
                op = OP_SET;
        end else begin
            unique case (off[11:10])
                2'b00:   op = OP_TRIG;
                2'b01:   op = OP_ST_EOI;
                default: op = OP_BAD;
            endcase
        end
    end

    assign legal = range_ok && (size == SIZE_8B) && (op != OP_BAD);

endmodule

// File: rtl/esb_pq_engine.sv
module esb_pq_engine
    import esb_pkg::*;
(
    input  esb_op_e    op,
    input  logic [1:0] set_val,
    input  logic [1:0] old_pq,
    output logic [1:0] new_pq,
    output logic [1:0] load_val
);
    logic [1:0] eoi_pq;
    logic [1:0] trig_pq;

    always_comb begin
        unique case (old_pq)
            2'b11:   eoi_pq = 2'b10;
            2'b10:   eoi_pq = 2'b00;
            default: eoi_pq = old_pq;
        endcase
        unique case (old_pq)
            2'b00:   trig_pq = 2'b10;
            2'b10:   trig_pq = 2'b11;
            default: trig_pq = old_pq;
        endcase
    end

    always_comb begin
        new_pq   = old_pq;
        load_val = 2'b00;
        unique case (op)
            OP_LD_EOI: begin
                new_pq   = eoi_pq;
                load_val = {1'b0, old_pq == 2'b11};
            end
            OP_GET:    load_val = old_pq;
            OP_SET: begin
                new_pq   = set_val;
                load_val = old_pq;
            end
            OP_TRIG:   new_pq = trig_pq;
            OP_ST_EOI: new_pq = eoi_pq;
            default:   new_pq = old_pq;
        endcase
    end

endmodule

// File: rtl/esb_page_ctrl.sv
module esb_page_ctrl
    import esb_pkg::*;
#(
    parameter  int NUM_Q      = 8,
    parameter  int PAGE_SHIFT = 12,
    parameter  int WORD_W     = 32,
    parameter  int NTF_LSB    = 4,
    parameter  int ESC_LSB    = 0,
    localparam int IDX_W      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int ADDR_W     = IDX_W + PAGE_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              desc_rd_req,
    output logic [IDX_W-1:0]  desc_idx,
    input  logic              desc_rd_valid,
    input  logic              desc_rd_ok,
    input  logic [WORD_W-1:0] desc_rd_word,
    output logic              desc_wr_en,
    output logic [WORD_W-1:0] desc_wr_word
);
    generate
        if (!(PAGE_SHIFT == 12 || PAGE_SHIFT == 16) || NUM_Q < 1) begin : g_bad_cfg
            $error("esb_page_ctrl: PAGE_SHIFT must be 12 or 16 and NUM_Q nonzero");
        end
    endgenerate

    esb_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              esc_q;
    esb_op_e           op_q;
    logic [1:0]        setv_q;
    logic [WORD_W-1:0] word_q;
    logic [1:0]        old_pq_q;
    logic              err_q;
    logic [1:0]        ldata_q;

    logic [IDX_W-1:0]  dec_idx;
    logic              dec_esc;
    esb_op_e           dec_op;
    logic [1:0]        dec_setv;
    logic              dec_legal;
    logic              accept;

    int                fld_lsb;
    logic [1:0]        cur_pq;
    logic [1:0]        nxt_pq;
    logic [1:0]        eng_load;
    logic [WORD_W-1:0] word_upd;

    esb_addr_decode #(
        .NUM_Q(NUM_Q), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_dec (
        .write(req_write), .addr(req_addr), .size(req_size),
        .idx(dec_idx), .esc_sel(dec_esc), .op(dec_op),
        .set_val(dec_setv), .legal(dec_legal)
    );

    esb_pq_engine u_eng (
        .op(op_q), .set_val(setv_q), .old_pq(cur_pq),
        .new_pq(nxt_pq), .load_val(eng_load)
    );

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign fld_lsb = esc_q ? ESC_LSB : NTF_LSB;
    assign cur_pq  = word_q[fld_lsb +: 2];

    always_comb begin
        word_upd = word_q;
        word_upd[fld_lsb +: 2] = nxt_pq;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = dec_legal ? ST_FETCH : ST_REPLY;
            ST_FETCH: if (desc_rd_valid) state_d = desc_rd_ok ? ST_APPLY : ST_REPLY;
            ST_APPLY: state_d = (nxt_pq != cur_pq) ? ST_WRITE : ST_REPLY;
            ST_WRITE: state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            esc_q    <= 1'b0;
            op_q     <= OP_GET;
            setv_q   <= 2'b00;
            word_q   <= '0;
            old_pq_q <= 2'b00;
            err_q    <= 1'b0;
            ldata_q  <= 2'b00;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    idx_q   <= dec_idx;
                    esc_q   <= dec_esc;
                    op_q    <= dec_op;
                    setv_q  <= dec_setv;
                    err_q   <= !dec_legal;
                    ldata_q <= 2'b00;
                end
                ST_FETCH: if (desc_rd_valid) begin
                    word_q <= desc_rd_word;
                    err_q  <= !desc_rd_ok;
                end
                ST_APPLY: begin
                    old_pq_q <= cur_pq;
                    word_q   <= word_upd;
                    ldata_q  <= eng_load;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        desc_rd_req  = 1'b0;
        desc_wr_en   = 1'b0;
        rsp_valid    = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready   = 1'b1;
            ST_FETCH: desc_rd_req = 1'b1;
            ST_WRITE: desc_wr_en  = 1'b1;
            ST_REPLY: rsp_valid   = 1'b1;
            default:  ;
        endcase
    end

    assign desc_idx     = idx_q;
    assign desc_wr_word = word_q;
    assign rsp_err      = err_q;
    assign rsp_rdata    = err_q ? {64{1'b1}} : {62'b0, ldata_q};

    // R10: strobes of different phases never overlap
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({desc_rd_req, desc_wr_en, rsp_valid}));

    // R10: an accepted request makes the port busy
    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: after a reply the port is ready again
    p_reply_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R8: a write-back carries a field different from the fetched one
    p_wb_changed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_en |-> (desc_wr_word[fld_lsb +: 2] != old_pq_q));

    // R8: a write-back is always followed by the reply
    p_wb_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_en |=> (rsp_valid && !rsp_err));

    // R9: an error reply never follows a write-back
    p_err_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> !$past(desc_wr_en));

endmodule

// File: tb/esb_page_ctrl_tb_top.sv
module esb_page_ctrl_tb_top;
    localparam int NQ     = 6;
    localparam int PSH    = 16;
    localparam int IW     = 3;
    localparam int AW     = IW + PSH + 1;
    localparam int WW     = 32;
    localparam logic [WW-1:0] BASE = 32'hA5A5_C3C0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'd3;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic          rsp_err;
    logic          desc_rd_req;
    logic [IW-1:0] desc_idx;
    logic          desc_rd_valid = 1'b0;
    logic          desc_rd_ok = 1'b0;
    logic [WW-1:0] desc_rd_word = '0;
    logic          desc_wr_en;
    logic [WW-1:0] desc_wr_word;

    logic [WW-1:0] mem [0:7];
    logic          mvld [0:7];
    int            wr_cnt = 0;
    int            rsp_seen = 0;
    logic [63:0]   log_d [0:63];
    logic          log_e [0:63];
    int            n_chk = 0;
    int            n_fail = 0;

    always #2.5 clk = ~clk;

    esb_page_ctrl #(.NUM_Q(NQ), .PAGE_SHIFT(PSH), .WORD_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .desc_rd_req(desc_rd_req), .desc_idx(desc_idx),
        .desc_rd_valid(desc_rd_valid), .desc_rd_ok(desc_rd_ok),
        .desc_rd_word(desc_rd_word),
        .desc_wr_en(desc_wr_en), .desc_wr_word(desc_wr_word)
    );

    // descriptor store model
    always @(posedge clk) begin
        desc_rd_valid <= desc_rd_req && !desc_rd_valid;
        desc_rd_word  <= mem[desc_idx];
        desc_rd_ok    <= mvld[desc_idx];
        if (desc_wr_en) begin
            mem[desc_idx] <= desc_wr_word;
            wr_cnt = wr_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (rsp_valid) begin
            log_d[rsp_seen % 64] = rsp_rdata;
            log_e[rsp_seen % 64] = rsp_err;
            rsp_seen = rsp_seen + 1;
        end
    end

    function automatic logic [AW-1:0] mk(input int q, input bit e, input int off);
        logic [AW-1:0] a;
        a = AW'(q) << (PSH + 1);
        a[PSH] = e;
        a = a | AW'(off);
        return a;
    endfunction

    function automatic logic [1:0] fld(input int q, input bit e);
        return e ? mem[q][1:0] : mem[q][5:4];
    endfunction

    task automatic put_fld(input int q, input bit e, input logic [1:0] v);
        if (e) mem[q][1:0] = v;
        else   mem[q][5:4] = v;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [1:0] sz,
                          output logic [63:0] d, output logic e);
        int base;
        base = rsp_seen;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        while (rsp_seen == base) @(negedge clk);
        d = log_d[base % 64];
        e = log_e[base % 64];
    endtask

    task automatic t_reset();
        chk("R10", "ready after reset", {63'b0, req_ready}, 64'd1);
        chk("R10", "no response after reset", {63'b0, rsp_valid}, 64'd0);
        chk("R8", "no write after reset", {63'b0, desc_wr_en}, 64'd0);
    endtask

    task automatic t_get_r4();
        logic [63:0] d; logic e; int w0;
        put_fld(1, 0, 2'b10); put_fld(1, 1, 2'b01);
        w0 = wr_cnt;
        access(0, mk(1, 0, 'h800), 2'd3, d, e);
        chk("R4", "get notify", d, 64'd2);
        chk("R1", "get notify err", {63'b0, e}, 64'd0);
        access(0, mk(1, 1, 'hBF8), 2'd3, d, e);
        chk("R1", "get escalate selects [1:0]", d, 64'd1);
        chk("R4", "get writes nothing", 64'(wr_cnt - w0), 64'd0);
    endtask

    task automatic t_set_r5();
        logic [63:0] d; logic e; int w0;
        w0 = wr_cnt;
        access(0, mk(2, 0, 'hF00), 2'd3, d, e);
        chk("R5", "set returns old", d, 64'd0);
        chk("R5", "set stores 11", {62'b0, fld(2, 0)}, 64'd3);
        chk("R8", "other bits kept", 64'(mem[2] & ~32'h30), 64'(BASE));
        chk("R8", "one write on change", 64'(wr_cnt - w0), 64'd1);
        access(0, mk(2, 0, 'hF10), 2'd3, d, e);
        chk("R5", "set again returns 11", d, 64'd3);
        chk("R8", "no write when unchanged", 64'(wr_cnt - w0), 64'd1);
        access(0, mk(2, 1, 'hD00), 2'd3, d, e);
        chk("R5", "set escalate 01", {62'b0, fld(2, 1)}, 64'd1);
        chk("R1", "notify untouched", {62'b0, fld(2, 0)}, 64'd3);
    endtask

    task automatic t_ld_eoi_r3();
        logic [63:0] d; logic e; int w0;
        put_fld(3, 1, 2'b11);
        access(0, mk(3, 1, 'h7F8), 2'd3, d, e);
        chk("R3", "eoi from 11 returns 1", d, 64'd1);
        chk("R3", "11 -> 10", {62'b0, fld(3, 1)}, 64'd2);
        access(0, mk(3, 1, 'h000), 2'd3, d, e);
        chk("R3", "eoi from 10 returns 0", d, 64'd0);
        chk("R3", "10 -> 00", {62'b0, fld(3, 1)}, 64'd0);
        w0 = wr_cnt;
        access(0, mk(3, 1, 'h100), 2'd3, d, e);
        chk("R8", "eoi on 00 no write", 64'(wr_cnt - w0), 64'd0);
        put_fld(3, 1, 2'b01);
        access(0, mk(3, 1, 'h400), 2'd3, d, e);
        chk("R3", "eoi on 01 returns 0", d, 64'd0);
        chk("R3", "01 kept", {62'b0, fld(3, 1)}, 64'd1);
    endtask

    task automatic t_trig_r6();
        logic [63:0] d; logic e; int w0;
        access(1, mk(4, 0, 'h000), 2'd3, d, e);
        chk("R6", "trigger data 0", d, 64'd0);
        chk("R6", "00 -> 10", {62'b0, fld(4, 0)}, 64'd2);
        access(1, mk(4, 0, 'h3F8), 2'd3, d, e);
        chk("R6", "10 -> 11", {62'b0, fld(4, 0)}, 64'd3);
        access(1, mk(4, 0, 'h008), 2'd3, d, e);
        chk("R6", "11 stays", {62'b0, fld(4, 0)}, 64'd3);
        put_fld(4, 1, 2'b01);
        w0 = wr_cnt;
        access(1, mk(4, 1, 'h010), 2'd3, d, e);
        chk("R6", "01 stays", {62'b0, fld(4, 1)}, 64'd1);
        chk("R8", "no write on 01 trigger", 64'(wr_cnt - w0), 64'd0);
    endtask

    task automatic t_st_eoi_r7();
        logic [63:0] d; logic e;
        access(1, mk(4, 0, 'h400), 2'd3, d, e);
        chk("R7", "store eoi data 0", d, 64'd0);
        chk("R7", "11 -> 10", {62'b0, fld(4, 0)}, 64'd2);
        access(1, mk(4, 0, 'h7F8), 2'd3, d, e);
        chk("R7", "10 -> 00", {62'b0, fld(4, 0)}, 64'd0);
    endtask

    task automatic t_high_off_r2();
        logic [63:0] d; logic e;
        put_fld(0, 1, 2'b11);
        access(0, mk(0, 1, 'hA800), 2'd3, d, e);
        chk("R2", "bits 15:12 ignored, get", d, 64'd3);
        access(0, mk(0, 1, 'h5E00), 2'd3, d, e);
        chk("R2", "bits 15:12 ignored, set 10", {62'b0, fld(0, 1)}, 64'd2);
    endtask

    task automatic t_errors_r9();
        logic [63:0] d; logic e; int w0; logic [WW-1:0] snap;
        w0 = wr_cnt;
        access(0, mk(5, 0, 'hC00), 2'd3, d, e);
        chk("R9", "invalid descriptor err", {63'b0, e}, 64'd1);
        chk("R9", "invalid descriptor data", d, {64{1'b1}});
        access(0, mk(7, 0, 'h800), 2'd3, d, e);
        chk("R9", "queue out of range err", {63'b0, e}, 64'd1);
        snap = mem[1];
        access(1, mk(1, 0, 'h900), 2'd3, d, e);
        chk("R9", "bad store offset err", {63'b0, e}, 64'd1);
        chk("R9", "bad store leaves word", 64'(mem[1]), 64'(snap));
        access(0, mk(1, 0, 'hC00), 2'd2, d, e);
        chk("R9", "4-byte access err", {63'b0, e}, 64'd1);
        chk("R9", "4-byte access data", d, {64{1'b1}});
        chk("R9", "no writes on errors", 64'(wr_cnt - w0), 64'd0);
    endtask

    task automatic t_b2b_r10();
        int base;
        base = rsp_seen;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = mk(0, 0, 'h000); req_size = 2'd3;
        @(negedge clk);
        chk("R10", "busy after accept", {63'b0, req_ready}, 64'd0);
        req_write = 1'b0; req_addr = mk(0, 0, 'h800);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (rsp_seen < base + 2) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R10", "exactly two responses", 64'(rsp_seen - base), 64'd2);
        chk("R10", "first reply trigger data", log_d[base % 64], 64'd0);
        chk("R10", "second sees written state", log_d[(base + 1) % 64], 64'd2);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            mem[i]  = BASE;
            mvld[i] = (i != 5);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_get_r4();
        t_set_r5();
        t_ld_eoi_r3();
        t_trig_r6();
        t_st_eoi_r7();
        t_high_off_r2();
        t_errors_r9();
        t_b2b_r10();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule